// File: doc/BRIEF.md
# Fault-Injection Run Outcome Classifier

This block decides how a single fault-injection run ended. A run begins with a start pulse. From then on a cycle counter advances, and the block watches three kinds of input. The first is the state-snapshot stream of the faulty system together with the golden snapshot of the fault-free run for the same point. The second is a flag that says whether the system outputs have diverged so far. The third is a set of event inputs for program completion and interrupt.

Each comparison made after the injection instant gives one verdict:

- **Vanished:** the state matches the golden state, so the fault has disappeared.
- **Failure:** the state differs and the outputs were hit.
- **Latent:** the state differs but the outputs are still clean.

A run that overruns a bound set well past the golden run length is cut off as a time-out.

When the verdict is final, the block raises a one-cycle stop request to the simulation harness. It then holds the 3-bit outcome until the next start. A latent verdict is provisional. After a programmable number of latent snapshots, comparison switches off and the run proceeds to its natural end. This avoids comparing a fault that will never clear.

Top module: `fi_outcome_classifier`

## Requirements
- R1: After reset `outcome` is 0 (none) and `stop_req` is low. Events and snapshots that arrive before the first start pulse change neither output.
- R2: A cycle with `run_start` high sets `outcome` to 0 and `stop_req` low on the next cycle, even in the middle of a run. It also samples `inject_time`, `golden_len` and `latent_limit`, and restarts the run counter. The counter is 0 in the cycle after the start pulse and advances by one per cycle.
- R3: A snapshot is compared only when the run counter is strictly greater than the sampled `inject_time`. Earlier snapshots are ignored.
- R4: A compared snapshot whose state equals its golden word ends the run with outcome 1 (no effect) and a stop pulse.
- R5: A compared snapshot that differs while `out_mismatch` is high ends the run with outcome 2 (failure) and a stop pulse.
- R6: A compared snapshot that differs while `out_mismatch` is low sets outcome 3 (latent) without a stop pulse, and the run goes on.
- R7: A completion event ends the run with a stop pulse. The outcome is 3 (latent) if any latent verdict was seen in the run, including one in the same cycle; otherwise it is 6 (completed). A failure or vanished verdict in the same cycle takes precedence over completion.
- R8: An interrupt event ends the run with outcome 4 (detected) and a stop pulse. It takes precedence over a failure verdict in the same cycle.
- R9: When the run counter reaches `golden_len` times the parameter TO_SCALE, the run ends with outcome 5 (time-out) and a stop pulse. This takes precedence over interrupt and failure in the same cycle.
- R10: Once `latent_limit` latent verdicts have been counted (when `latent_limit` is non-zero), later snapshots are ignored until the run ends by completion, interrupt or time-out. A `latent_limit` of 0 means no cap.
- R11: `stop_req` is high for exactly one cycle per run. After it, `outcome` holds and every event and snapshot is ignored until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Starts a new run; samples the run settings |
| inject_time | input | CW | Run-counter value at which the fault is inserted |
| golden_len | input | CW | Fault-free run length in cycles |
| latent_limit | input | LW | Latent verdicts before comparison turns off; 0 = no cap |
| snap_valid | input | 1 | Snapshot pair present this cycle |
| snap_state | input | SW | State word of the faulty system |
| snap_golden | input | SW | Matching golden state word |
| out_mismatch | input | 1 | System outputs have diverged from the golden run |
| ev_done | input | 1 | Program-completion event |
| ev_irq | input | 1 | Interrupt / error-detection event |
| stop_req | output | 1 | One-cycle request to stop the run |
| outcome | output | 3 | Outcome code: 0 none, 1 no effect, 2 failure, 3 latent, 4 detected, 5 time-out, 6 completed |

## Verification
The hardest situation to reach is a run that has entered the blind phase. Such a run must ignore a failing snapshot and later end on a completion event while still reporting latent. The stimulus uses a cap of two with injection at counter 0. It then feeds two differing snapshots with clean outputs, followed by a differing snapshot with corrupted outputs and then a matching one. Finally it raises completion. The time-out path is reached with a short golden length, so that the bound falls within a dozen cycles. The cycle that reaches the bound also carries an interrupt and a failing snapshot, which checks the priority order.

// File: rtl/fi_cls_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the fault-injection outcome classifier.
// Assumes: outcome codes are fixed; the harness decodes them.
package fi_cls_pkg;

    typedef enum logic [2:0] {
        OC_NONE      = 3'd0,
        OC_NO_EFFECT = 3'd1,
        OC_FAILURE   = 3'd2,
        OC_LATENT    = 3'd3,
        OC_DETECTED  = 3'd4,
        OC_TIMEOUT   = 3'd5,
        OC_COMPLETED = 3'd6
    } outcome_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_ACTIVE = 2'd1,
        RS_BLIND  = 2'd2,
        RS_FINAL  = 2'd3
    } run_state_e;

    typedef struct packed {
        logic vanish;
        logic fail;
        logic latent;
    } verdict_t;

endpackage

// File: rtl/fi_run_timer.sv
`timescale 1ns/1ps
// Module: run cycle counter, injection window and time-out bound.
// Does: counts cycles from a start pulse; flags cycles past the injection
//       instant and the cycle the time-out bound is reached.
// Assumes: inject_time and golden_len are valid in the start cycle.
module fi_run_timer #(
    parameter int CW       = 16,
    parameter int TO_SCALE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_start,
    input  logic          active,
    input  logic [CW-1:0] inject_time,
    input  logic [CW-1:0] golden_len,
    output logic          past_inject,
    output logic          timeout_hit
);
    localparam int SCALE_W = $clog2(TO_SCALE + 1);
    localparam int TW      = CW + SCALE_W;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] limit_q;
    logic [TW-1:0] inj_q;

    // Latch run settings at start; count saturating while a run is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= '0;
            inj_q   <= '0;
        end else if (run_start) begin
            cnt_q   <= '0;
            limit_q <= TW'(golden_len) * TW'(TO_SCALE);
            inj_q   <= TW'(inject_time);
        end else if (active && (cnt_q != {TW{1'b1}})) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    // Window and bound decodes.
    always_comb begin
        past_inject = (cnt_q > inj_q);
        timeout_hit = active && (cnt_q >= limit_q);
    end

    // R2: the counter never moves backwards inside a run.
    p_cnt_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !run_start) |=> (cnt_q >= $past(cnt_q)));

    // R3: no comparison window at counter zero unless injection precedes it.
    p_window_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (cnt_q == '0));

endmodule

// File: rtl/fi_snap_compare.sv
`timescale 1ns/1ps
// Module: snapshot comparator.
// Does: compares the faulty state with the golden word lane by lane and
//       turns the result plus the output-mismatch flag into a verdict.
// Assumes: snap_state and snap_golden belong to the same snapshot point.
module fi_snap_compare #(
    parameter int SW     = 32,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snap_valid,
    input  logic                enable,
    input  logic [SW-1:0]       snap_state,
    input  logic [SW-1:0]       snap_golden,
    input  logic                out_mismatch,
    output fi_cls_pkg::verdict_t verdict
);
    localparam int NLANE = (SW + LANE_W - 1) / LANE_W;
    localparam int PADW  = NLANE * LANE_W;

    logic [PADW-1:0]  diff_pad;
    logic [NLANE-1:0] lane_diff;
    logic             any_diff;
    logic             go;

    // Bitwise difference, zero-padded to whole lanes.
    always_comb diff_pad = PADW'(snap_state ^ snap_golden);

    // One reduction per lane keeps the OR tree balanced for wide states.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        always_comb lane_diff[l] = |diff_pad[l*LANE_W +: LANE_W];
    end

    // Verdict decode for an enabled snapshot.
    always_comb begin
        any_diff       = |lane_diff;
        go             = snap_valid && enable;
        verdict.vanish = go && !any_diff;
        verdict.fail   = go && any_diff && out_mismatch;
        verdict.latent = go && any_diff && !out_mismatch;
    end

    // R4: a disabled comparator never reports a verdict across a cycle.
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(snap_valid && enable) |-> (verdict == '0));

endmodule

// File: rtl/fi_verdict_fsm.sv
`timescale 1ns/1ps
// Module: run state machine and outcome register.
// Does: applies the priority time-out > interrupt > failure > vanished >
//       completion > latent, raises the one-cycle stop, counts latent
//       verdicts and turns comparison off at the cap.
// Assumes: verdict is already qualified by cmp_enable.
module fi_verdict_fsm #(
    parameter int LW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_start,
    input  logic                  ev_done,
    input  logic                  ev_irq,
    input  logic                  timeout_hit,
    input  logic                  past_inject,
    input  fi_cls_pkg::verdict_t  verdict,
    input  logic [LW-1:0]         latent_limit,
    output logic                  cmp_enable,
    output logic                  active,
    output logic                  stop_req,
    output fi_cls_pkg::outcome_e  outcome
);
    import fi_cls_pkg::*;

    run_state_e      st_q, st_d;
    outcome_e        oc_q, oc_d;
    logic            stop_q, stop_d;
    logic [LW-1:0]   lat_cnt_q, lat_cnt_d, lat_inc;
    logic            lat_seen_q, lat_seen_d;
    logic [LW-1:0]   cap_q;

    // Run status decodes for the timer and comparator.
    always_comb begin
        active     = (st_q == RS_ACTIVE) || (st_q == RS_BLIND);
        cmp_enable = (st_q == RS_ACTIVE) && past_inject;
        lat_inc    = lat_cnt_q + LW'(1);
    end

    // Next-state and outcome selection in priority order.
    always_comb begin
        st_d       = st_q;
        oc_d       = oc_q;
        stop_d     = 1'b0;
        lat_cnt_d  = lat_cnt_q;
        lat_seen_d = lat_seen_q;
        if (run_start) begin
            st_d       = RS_ACTIVE;
            oc_d       = OC_NONE;
            lat_cnt_d  = '0;
            lat_seen_d = 1'b0;
        end else if (active) begin
            if (timeout_hit) begin
                st_d = RS_FINAL; oc_d = OC_TIMEOUT; stop_d = 1'b1;
            end else if (ev_irq) begin
                st_d = RS_FINAL; oc_d = OC_DETECTED; stop_d = 1'b1;
            end else if (verdict.fail) begin
                st_d = RS_FINAL; oc_d = OC_FAILURE; stop_d = 1'b1;
            end else if (verdict.vanish) begin
                st_d = RS_FINAL; oc_d = OC_NO_EFFECT; stop_d = 1'b1;
            end else if (ev_done) begin
                st_d   = RS_FINAL;
                stop_d = 1'b1;
                oc_d   = (lat_seen_q || verdict.latent) ? OC_LATENT : OC_COMPLETED;
            end else if (verdict.latent) begin
                oc_d       = OC_LATENT;
                lat_seen_d = 1'b1;
                lat_cnt_d  = lat_inc;
                if ((cap_q != '0) && (lat_inc == cap_q))
                    st_d = RS_BLIND;
            end
        end
    end

    // State, outcome and latent-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= RS_IDLE;
            oc_q       <= OC_NONE;
            stop_q     <= 1'b0;
            lat_cnt_q  <= '0;
            lat_seen_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            oc_q       <= oc_d;
            stop_q     <= stop_d;
            lat_cnt_q  <= lat_cnt_d;
            lat_seen_q <= lat_seen_d;
        end
    end

    // Latent cap sampled once per run.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (run_start) cap_q <= latent_limit;
    end

    always_comb begin
        stop_req = stop_q;
        outcome  = oc_q;
    end

    p_stop_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> !stop_q);

    p_final_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_FINAL && !run_start) |=> ($stable(oc_q) && !stop_q));

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (oc_q == OC_NONE && !stop_q));

    p_timeout_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && timeout_hit && !run_start) |=> (stop_q && oc_q == OC_TIMEOUT));

    p_irq_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev_irq && !timeout_hit && !run_start) |=> (stop_q && oc_q == OC_DETECTED));

    p_latent_runs_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_ACTIVE && verdict.latent && !run_start && !timeout_hit
         && !ev_irq && !ev_done) |=> (!stop_q && oc_q == OC_LATENT));

    p_blind_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_BLIND && !run_start && !timeout_hit && !ev_irq && !ev_done)
        |=> (st_q == RS_BLIND && !stop_q && $stable(oc_q)));

endmodule

// File: rtl/fi_outcome_classifier.sv
`timescale 1ns/1ps
// Module: top of the fault-injection run outcome classifier.
// Does: wires the run timer, snapshot comparator and verdict machine.
// Assumes: one run at a time; the harness stops the run on stop_req.
module fi_outcome_classifier #(
    parameter int SW       = 32,
    parameter int CW       = 16,
    parameter int LW       = 4,
    parameter int TO_SCALE = 4,
    parameter int LANE_W   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_start,
    input  logic [CW-1:0] inject_time,
    input  logic [CW-1:0] golden_len,
    input  logic [LW-1:0] latent_limit,
    input  logic          snap_valid,
    input  logic [SW-1:0] snap_state,
    input  logic [SW-1:0] snap_golden,
    input  logic          out_mismatch,
    input  logic          ev_done,
    input  logic          ev_irq,
    output logic          stop_req,
    output logic [2:0]    outcome
);
    import fi_cls_pkg::*;

    logic     past_inject;
    logic     timeout_hit;
    logic     cmp_enable;
    logic     active;
    verdict_t verdict;
    outcome_e oc;

    fi_run_timer #(.CW(CW), .TO_SCALE(TO_SCALE)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_start   (run_start),
        .active      (active),
        .inject_time (inject_time),
        .golden_len  (golden_len),
        .past_inject (past_inject),
        .timeout_hit (timeout_hit)
    );

    fi_snap_compare #(.SW(SW), .LANE_W(LANE_W)) cmp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .snap_valid   (snap_valid),
        .enable       (cmp_enable),
        .snap_state   (snap_state),
        .snap_golden  (snap_golden),
        .out_mismatch (out_mismatch),
        .verdict      (verdict)
    );

    fi_verdict_fsm #(.LW(LW)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_start    (run_start),
        .ev_done      (ev_done),
        .ev_irq       (ev_irq),
        .timeout_hit  (timeout_hit),
        .past_inject  (past_inject),
        .verdict      (verdict),
        .latent_limit (latent_limit),
        .cmp_enable   (cmp_enable),
        .active       (active),
        .stop_req     (stop_req),
        .outcome      (oc)
    );

    // Plain-vector view of the outcome code.
    always_comb outcome = oc;

endmodule

// File: tb/fi_outcome_classifier_tb_top.sv
`timescale 1ns/1ps
module fi_outcome_classifier_tb_top;

    localparam int SW = 32, CW = 16, LW = 4, TO_SCALE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_start = 1'b0;
    logic [CW-1:0] inject_time = '0;
    logic [CW-1:0] golden_len = '0;
    logic [LW-1:0] latent_limit = '0;
    logic          snap_valid = 1'b0;
    logic [SW-1:0] snap_state = '0;
    logic [SW-1:0] snap_golden = '0;
    logic          out_mismatch = 1'b0;
    logic          ev_done = 1'b0;
    logic          ev_irq = 1'b0;
    logic          stop_req;
    logic [2:0]    outcome;

    always #4 clk = ~clk;

    fi_outcome_classifier #(.SW(SW), .CW(CW), .LW(LW), .TO_SCALE(TO_SCALE)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_start(run_start),
        .inject_time(inject_time), .golden_len(golden_len),
        .latent_limit(latent_limit), .snap_valid(snap_valid),
        .snap_state(snap_state), .snap_golden(snap_golden),
        .out_mismatch(out_mismatch), .ev_done(ev_done), .ev_irq(ev_irq),
        .stop_req(stop_req), .outcome(outcome)
    );

    typedef struct {
        logic       stop;
        logic [2:0] oc;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done_flag = 0;

    localparam logic [2:0] NONE = 3'd0, NOEFF = 3'd1, FAIL_C = 3'd2, LAT = 3'd3,
                           DET = 3'd4, TOUT = 3'd5, COMP = 3'd6;
    localparam logic [SW-1:0] G  = 32'hA5A5_0F0F;
    localparam logic [SW-1:0] BD = 32'hA5A5_0F8F;

    // Monitor: pops expectations and compares away from the active edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (stop_req !== e.stop || outcome !== e.oc) begin
                n_fail++;
                $display("FAIL %s: stop=%0b outcome=%0d expected stop=%0b outcome=%0d",
                         e.tag, stop_req, outcome, e.stop, e.oc);
            end
        end
    end

    task automatic push(input logic s, input logic [2:0] o, input string tag);
        exp_t e;
        e.stop = s; e.oc = o; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: one cycle of stimulus and the expected result after it.
    task automatic step(input logic sv, input logic [SW-1:0] st, input logic mm,
                        input logic dn, input logic iq,
                        input logic es, input logic [2:0] eo, input string tag);
        @(negedge clk);
        run_start = 1'b0; snap_valid = sv; snap_state = st; snap_golden = G;
        out_mismatch = mm; ev_done = dn; ev_irq = iq;
        @(posedge clk); #1;
        push(es, eo, tag);
    endtask

    task automatic start_run(input int inj, input int glen, input int llim);
        @(negedge clk);
        run_start = 1'b1; snap_valid = 1'b0; ev_done = 1'b0; ev_irq = 1'b0;
        out_mismatch = 1'b0;
        inject_time = CW'(inj); golden_len = CW'(glen); latent_limit = LW'(llim);
        @(posedge clk); #1;
        push(1'b0, NONE, "R2 start clears");
    endtask

    initial begin
        // R1: reset state, then events with no run open.
        repeat (3) @(posedge clk);
        #1 push(1'b0, NONE, "R1 reset");
        @(negedge clk); rst_n = 1'b1;
        step(1, BD, 1, 0, 1, 0, NONE, "R1 irq before run");
        step(1, BD, 1, 1, 0, 0, NONE, "R1 done before run");

        // R3/R4: inject at 3; counter 0..3 ignored, 4 compared and equal.
        start_run(3, 100, 0);
        for (int i = 0; i < 4; i++) step(1, BD, 1, 0, 0, 0, NONE, "R3 before injection");
        step(1, G, 0, 0, 0, 1, NOEFF, "R4 vanished");
        // R11: held, later stimulus ignored.
        step(1, BD, 1, 0, 0, 0, NOEFF, "R11 hold after failing snap");
        step(0, G, 0, 0, 1, 0, NOEFF, "R11 hold after irq");

        // R5: failure at counter 1 with inject 0.
        start_run(0, 100, 0);
        step(1, BD, 1, 0, 0, 0, NONE, "R3 counter equals inject");
        step(1, BD, 1, 0, 0, 1, FAIL_C, "R5 failure");
        step(0, G, 0, 0, 0, 0, FAIL_C, "R11 single pulse");

        // R6/R10 (cap 0): repeated latent, then vanish.
        start_run(0, 100, 0);
        step(0, G, 0, 0, 0, 0, NONE, "R6 idle");
        for (int i = 0; i < 3; i++) step(1, BD, 0, 0, 0, 0, LAT, "R6 latent no stop");
        step(1, G, 0, 0, 0, 1, NOEFF, "R10 zero cap keeps comparing");

        // R7: latent in the same cycle as completion.
        start_run(0, 100, 0);
        step(0, G, 0, 0, 0, 0, NONE, "R7 idle");
        step(1, BD, 0, 1, 0, 1, LAT, "R7 latent with done");

        // R2: restart mid-run, then completion with no latent.
        start_run(0, 100, 0);
        step(0, G, 0, 0, 0, 0, NONE, "R2 idle");
        step(1, BD, 0, 0, 0, 0, LAT, "R6 latent before restart");
        start_run(0, 100, 0);
        step(0, G, 0, 1, 0, 1, COMP, "R7 completed");

        // R8: interrupt with failing snapshot in the same cycle.
        start_run(0, 100, 0);
        step(0, G, 0, 0, 0, 0, NONE, "R8 idle");
        step(1, BD, 1, 0, 1, 1, DET, "R8 irq beats failure");

        // R10: cap of two, then failing and equal snapshots ignored.
        start_run(0, 100, 2);
        step(0, G, 0, 0, 0, 0, NONE, "R10 idle");
        step(1, BD, 0, 0, 0, 0, LAT, "R10 latent 1");
        step(1, BD, 0, 0, 0, 0, LAT, "R10 latent 2");
        step(1, BD, 1, 0, 0, 0, LAT, "R10 failing snap ignored");
        step(1, G, 0, 0, 0, 0, LAT, "R10 equal snap ignored");
        step(0, G, 0, 1, 0, 1, LAT, "R10 R7 done after cap");

        // R9: golden 3 x 4 = 12; counter 0..11 quiet, 12 times out.
        start_run(0, 3, 0);
        for (int i = 0; i < 12; i++) step(0, G, 0, 0, 0, 0, NONE, "R9 before bound");
        step(1, BD, 1, 0, 1, 1, TOUT, "R9 timeout beats irq and failure");
        step(0, G, 0, 0, 0, 0, TOUT, "R11 timeout held");

        @(negedge clk); @(negedge clk);
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            done_flag = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule